// File: doc/BRIEF.md
# Early-Out Iterative Integer Divider

This block divides a 32-bit dividend by a 32-bit divisor, as signed or as unsigned numbers, and produces quotient and remainder. It works by restoring division and settles one quotient bit per clock. Before it starts iterating, it works out how much of the dividend is only zero fill or sign copies. It then runs just enough steps to cover the remaining significant width, rounded up to a multiple of 8 bits. Small dividends therefore finish sooner, and the latency is still a fixed function of the dividend value alone.

The issuing pipeline raises a one-cycle start request together with the operands and a signed flag. The block holds busy high for the whole operation, and the pipeline uses it to hold back any further multiply or divide work. A start request that arrives while busy is high is dropped. On completion, a one-cycle done pulse comes with the quotient (destined for LO) and the remainder (destined for HI). Both stay on the outputs until the next completion. Division by zero is not reported as an error. It completes at the normal latency and returns a fixed pattern.

Top module: `ediv_top`

## Requirements
- R1: While reset is applied and in the first cycle after it, `busy_o` and `done_o` are 0 and `quot_o` and `rem_o` are all zeros.
- R2: With `signed_i` = 0 and a nonzero divisor, the block returns quot = floor(dividend/divisor) and rem = dividend - quot*divisor, with both operands taken as unsigned.
- R3: With `signed_i` = 1 and a nonzero divisor, both operands are taken as two's complement. The quotient is truncated toward zero and a nonzero remainder carries the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R4: With `signed_i` = 0, the step count W is the smallest of 8, 16, 24 and 32 for which the dividend is below 2^W.
- R5: With `signed_i` = 1, the step count W is the smallest of 8, 16, 24 and 32 for which the dividend lies within the W-bit two's-complement range [-2^(W-1), 2^(W-1)-1].
- R6: If start is sampled at clock edge E while the block is idle, `busy_o` is 1 for exactly W+1 cycles beginning right after E. `done_o` is 1 for the single cycle that follows, during which `busy_o` is 0. No divide keeps busy high for more than 33 cycles.
- R7: A start request sampled while `busy_o` is 1 has no effect on the running operation's results or timing.
- R8: A zero divisor completes at the same latency as a nonzero one, with quot = 0xFFFFFFFF and rem equal to the raw dividend, in either signed mode.
- R9: A start request sampled in the cycle where `done_o` is 1 is accepted, so operations can run back to back with no gap cycle.
- R10: `quot_o` and `rem_o` change only in a cycle where `done_o` is 1, and otherwise hold the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a divide; sampled only while idle |
| signed_i | input | 1 | 1 for two's-complement division, 0 for unsigned |
| dividend_i | input | 32 | Dividend (numerator) |
| divisor_i | input | 32 | Divisor (denominator) |
| busy_o | output | 1 | Divide in progress; stall further multiply/divide requests |
| done_o | output | 1 | One-cycle pulse: results are valid and the block is idle |
| quot_o | output | 32 | Quotient (LO destination), held until the next completion |
| rem_o | output | 32 | Remainder (HI destination), held until the next completion |

## Verification
The bench builds the divider with its default parameters: a 32-bit datapath and 8-bit width granules. With these values, all four step counts (8, 16, 24, 32) and every boundary between them are reachable with small hand-picked dividends such as 255/256, -128/-129 and 127/128. The defaults also allow the most-negative-by-minus-one case and the maximum 33-cycle busy window. A pseudo-random sweep that forces each width class in turn, with back-to-back issue and start requests injected mid-operation, exercises the latency path and the result path against a behavioural model on every clock.

// File: rtl/ediv_pkg.sv
// Shared types for the early-out divider.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package ediv_pkg;

    // Control states of the divider sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

endpackage

// File: rtl/ediv_width_detect.sv
// Works out how many restoring steps a dividend needs. The answer is the
// smallest multiple of CHUNK (up to XLEN) whose width holds the value: as
// unsigned when sgn=0, as two's complement when sgn=1.
// Assumes: XLEN is a multiple of CHUNK. Only dividend bits
// [XLEN-1:CHUNK-1] can affect the answer, so only those are passed in.
module ediv_width_detect #(
    parameter int XLEN  = 32,
    parameter int CHUNK = 8,
    parameter int CNTW  = $clog2(XLEN + 1),
    parameter int HIW   = XLEN - CHUNK + 1
) (
    input  logic [HIW-1:0]  dvd_hi,   // dividend bits [XLEN-1:CHUNK-1]
    input  logic            sgn,
    output logic [CNTW-1:0] steps
);
    localparam int NCHUNK = XLEN / CHUNK;

    logic [NCHUNK:1] fits;

    // One width test per granule boundary below full width.
    for (genvar k = 1; k < NCHUNK; k++) begin : g_fit
        localparam int SLO = k * CHUNK - CHUNK;      // sign-run lowest bit
        localparam int ULO = k * CHUNK - CHUNK + 1;  // zero-run lowest bit
        assign fits[k] = sgn ? ((&dvd_hi[HIW-1:SLO]) | ~(|dvd_hi[HIW-1:SLO]))
                             : ~(|dvd_hi[HIW-1:ULO]);
    end
    assign fits[NCHUNK] = 1'b1;

    // Pick the narrowest granule that holds the value.
    always_comb begin
        steps = CNTW'(XLEN);
        for (int k = NCHUNK - 1; k >= 1; k--) begin
            if (fits[k]) steps = CNTW'(k * CHUNK);
        end
    end
endmodule

// File: rtl/ediv_step.sv
// One restoring-division step: shift the next dividend bit into the partial
// remainder, subtract the divisor where it fits, and shift out a quotient bit.
// Assumes: rem_i < dsr_i on entry (true for any nonzero divisor).
module ediv_step #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] rem_i,
    input  logic [XLEN-1:0] quo_i,
    input  logic [XLEN-1:0] dsr_i,
    output logic [XLEN-1:0] rem_o,
    output logic [XLEN-1:0] quo_o
);
    logic [XLEN:0]   shifted;
    logic [XLEN-1:0] diff;
    logic            ge;

    // Trial subtraction and restore decision.
    always_comb begin
        shifted = {rem_i, quo_i[XLEN-1]};
        ge      = (shifted >= {1'b0, dsr_i});
        diff    = shifted[XLEN-1:0] - dsr_i;
        rem_o   = ge ? diff : shifted[XLEN-1:0];
        quo_o   = {quo_i[XLEN-2:0], ge};
    end
endmodule

// File: rtl/ediv_sign_fix.sv
// Final correction: gives the unsigned magnitudes the requested signs and
// substitutes the fixed divide-by-zero pattern.
// Assumes: the magnitudes come from a completed run of restoring steps.
module ediv_sign_fix #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] quo_mag,
    input  logic [XLEN-1:0] rem_mag,
    input  logic            neg_q,
    input  logic            neg_r,
    input  logic            div_zero,
    input  logic [XLEN-1:0] dvd_raw,
    output logic [XLEN-1:0] quo,
    output logic [XLEN-1:0] rem
);
    // Sign application and zero-divisor override.
    always_comb begin
        if (div_zero) begin
            quo = '1;
            rem = dvd_raw;
        end else begin
            quo = neg_q ? (-quo_mag) : quo_mag;
            rem = neg_r ? (-rem_mag) : rem_mag;
        end
    end
endmodule

// File: rtl/ediv_top.sv
// Early-out iterative divider. It takes a start pulse while idle, loads the
// operand magnitudes pre-shifted so that only the significant dividend width
// is iterated, runs one restoring step per clock, then spends one cycle on
// sign correction and raises done with the registered results.
// Assumes: the issuer stalls while busy_o is high. Starts seen while busy
// are dropped.
module ediv_top #(
    parameter int XLEN  = 32,
    parameter int CHUNK = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            signed_i,
    input  logic [XLEN-1:0] dividend_i,
    input  logic [XLEN-1:0] divisor_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] quot_o,
    output logic [XLEN-1:0] rem_o
);
    import ediv_pkg::*;

    localparam int CNTW = $clog2(XLEN + 1);
    localparam int HIW  = XLEN - CHUNK + 1;
    localparam int RUNW = CNTW + 1;

    div_state_e      state_q;
    logic [CNTW-1:0] cnt_q;
    logic [XLEN-1:0] rem_q, quo_q, dsr_q, dvd_q;
    logic            neg_q_q, neg_r_q, dz_q;

    logic [CNTW-1:0] steps, pre_sh;
    logic [XLEN-1:0] dvd_mag, dsr_mag;
    logic [XLEN-1:0] rem_nx, quo_nx;
    logic [XLEN-1:0] quo_fin, rem_fin;
    logic            accept;

    // Operand magnitudes and the start handshake.
    always_comb begin
        accept  = start_i && (state_q == ST_IDLE);
        dvd_mag = (signed_i && dividend_i[XLEN-1]) ? (-dividend_i) : dividend_i;
        dsr_mag = (signed_i && divisor_i[XLEN-1])  ? (-divisor_i)  : divisor_i;
        pre_sh  = CNTW'(XLEN) - steps;
    end

    ediv_width_detect #(
        .XLEN (XLEN),
        .CHUNK(CHUNK),
        .CNTW (CNTW),
        .HIW  (HIW)
    ) u_width (
        .dvd_hi(dividend_i[XLEN-1:CHUNK-1]),
        .sgn   (signed_i),
        .steps (steps)
    );

    ediv_step #(.XLEN(XLEN)) u_step (
        .rem_i(rem_q),
        .quo_i(quo_q),
        .dsr_i(dsr_q),
        .rem_o(rem_nx),
        .quo_o(quo_nx)
    );

    ediv_sign_fix #(.XLEN(XLEN)) u_fix (
        .quo_mag (quo_q),
        .rem_mag (rem_q),
        .neg_q   (neg_q_q),
        .neg_r   (neg_r_q),
        .div_zero(dz_q),
        .dvd_raw (dvd_q),
        .quo     (quo_fin),
        .rem     (rem_fin)
    );

    // Sequencer and iteration datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rem_q   <= '0;
            quo_q   <= '0;
            dsr_q   <= '0;
            dvd_q   <= '0;
            neg_q_q <= 1'b0;
            neg_r_q <= 1'b0;
            dz_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_RUN;
                        cnt_q   <= steps;
                        rem_q   <= '0;
                        quo_q   <= dvd_mag << pre_sh;
                        dsr_q   <= dsr_mag;
                        dvd_q   <= dividend_i;
                        neg_q_q <= signed_i && (dividend_i[XLEN-1] ^ divisor_i[XLEN-1]);
                        neg_r_q <= signed_i && dividend_i[XLEN-1];
                        dz_q    <= (divisor_i == '0);
                    end
                end
                ST_RUN: begin
                    rem_q <= rem_nx;
                    quo_q <= quo_nx;
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CNTW'(1)) state_q <= ST_FIX;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Result registers and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            quot_o <= '0;
            rem_o  <= '0;
        end else begin
            done_o <= (state_q == ST_FIX);
            if (state_q == ST_FIX) begin
                quot_o <= quo_fin;
                rem_o  <= rem_fin;
            end
        end
    end

    assign busy_o = (state_q != ST_IDLE);

    // Length of the current busy run, kept for the bound check below.
    localparam logic [RUNW-1:0] MAX_RUN = RUNW'(XLEN + 1);
    logic [RUNW-1:0] busy_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_run_q <= '0;
        else if (busy_o) busy_run_q <= busy_run_q + 1'b1;
        else             busy_run_q <= '0;
    end

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run_q <= MAX_RUN);                                          // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                             // R6
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));                          // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(quot_o) && $stable(rem_o)));                // R10
    AST_IGNORE_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !(state_q == ST_FIX)) |=> busy_o);         // R7
endmodule

// File: tb/ediv_top_tb_top.sv
// Self-checking bench: a behavioural cycle model predicts busy, done and the
// results on every clock, and the outputs are compared at each falling edge.
module ediv_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        signed_i = 1'b0;
    logic [31:0] dividend_i = '0;
    logic [31:0] divisor_i = '0;
    logic        busy_o, done_o;
    logic [31:0] quot_o, rem_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    ediv_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o), .rem_o(rem_o)
    );

    // ---------------- reference model ----------------
    string       cur_tag = "R1";
    string       run_tag = "R1";
    int          left = 0;
    bit          exp_busy = 0, exp_done = 0;
    logic [31:0] exp_q = '0, exp_r = '0, pend_q = '0, pend_r = '0;

    function automatic int width_of(logic [31:0] a, bit s);
        longint v;
        if (s) begin
            v = longint'($signed(a));
            if (v >= -128 && v <= 127) return 8;
            if (v >= -32768 && v <= 32767) return 16;
            if (v >= -8388608 && v <= 8388607) return 24;
            return 32;
        end
        if (a < 32'h100) return 8;
        if (a < 32'h1_0000) return 16;
        if (a < 32'h100_0000) return 24;
        return 32;
    endfunction

    task automatic ref_div(input logic [31:0] a, input logic [31:0] b, input bit s,
                           output logic [31:0] q, output logic [31:0] r);
        longint sa, sb, lq, lr;
        if (b == 0) begin
            q = 32'hFFFF_FFFF; r = a;
        end else begin
            sa = s ? longint'($signed(a)) : longint'({32'd0, a});
            sb = s ? longint'($signed(b)) : longint'({32'd0, b});
            lq = sa / sb;
            lr = sa % sb;
            q = lq[31:0]; r = lr[31:0];
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            left = 0; exp_busy = 0; exp_done = 0; exp_q = '0; exp_r = '0;
        end else begin
            exp_done = 0;
            if (left > 0) begin
                left--;
                if (left == 0) begin
                    exp_done = 1; exp_q = pend_q; exp_r = pend_r;
                end
            end else if (start_i) begin
                ref_div(dividend_i, divisor_i, signed_i, pend_q, pend_r);
                left = width_of(dividend_i, signed_i) + 1;
                run_tag = cur_tag;
            end
            exp_busy = (left > 0);
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (!finished && $time > 15) begin
            checks++;
            if (busy_o !== exp_busy || done_o !== exp_done ||
                quot_o !== exp_q || rem_o !== exp_r) begin
                errors++;
                $display("FAIL %s (R6/R10 timing+hold) t=%0t busy %b/%b done %b/%b quot %h/%h rem %h/%h (actual/expected)",
                         (!rst_n) ? "R1" : run_tag, $time, busy_o, exp_busy, done_o, exp_done,
                         quot_o, exp_q, rem_o, exp_r);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic issue(input logic [31:0] a, input logic [31:0] b, input bit s, input string tag);
        @(negedge clk);
        cur_tag = tag; dividend_i = a; divisor_i = b; signed_i = s; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic drain();
        while (exp_busy || exp_done) @(negedge clk);
    endtask

    task automatic do_op(input logic [31:0] a, input logic [31:0] b, input bit s, input string tag);
        issue(a, b, s, tag);
        drain();
    endtask

    // R7: stray starts with other operands arrive mid-operation and in the last busy cycle
    task automatic do_op_noisy(input logic [31:0] a, input logic [31:0] b, input bit s);
        issue(a, b, s, "R7");
        repeat (3) @(negedge clk);
        dividend_i = 32'h7; divisor_i = 32'h2; signed_i = ~s; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!(exp_busy && left == 1)) @(negedge clk);
        dividend_i = 32'h1234_5678; divisor_i = 32'h3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        drain();
    endtask

    // R9: the second request is raised in the very cycle done is high
    task automatic back_to_back(input logic [31:0] a, input logic [31:0] b,
                                input logic [31:0] c, input logic [31:0] d, input bit s);
        issue(a, b, s, "R9");
        while (!exp_done) @(negedge clk);
        cur_tag = "R9"; dividend_i = c; divisor_i = d; signed_i = s; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        drain();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- test sequence ----------------
    logic [31:0] lfsr = 32'hACE1_2468;
    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values (checked by the per-cycle compare under tag R1)
        checks++;
        if (busy_o !== 1'b0 || done_o !== 1'b0 || quot_o !== '0 || rem_o !== '0) begin
            errors++;
            $display("FAIL R1 reset state busy %b done %b quot %h rem %h (expected 0 0 0 0)",
                     busy_o, done_o, quot_o, rem_o);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 + R4: unsigned across width classes and their boundaries
        do_op(32'd200, 32'd7, 0, "R2_R4");
        do_op(32'd255, 32'd16, 0, "R4");
        do_op(32'd256, 32'd16, 0, "R4");
        do_op(32'h0000_1234, 32'h13, 0, "R2");
        do_op(32'h00AB_CDEF, 32'h100, 0, "R2_R4");
        do_op(32'hFFFF_FFFF, 32'd3, 0, "R2_R4");
        do_op(32'd5, 32'd9, 0, "R2");
        do_op(32'h8000_0000, 32'hFFFF_FFFF, 0, "R2");
        do_op(32'h0, 32'd17, 0, "R2");

        // R3 + R5: signed, truncation and width boundaries
        do_op(-32'sd7, 32'd2, 1, "R3");
        do_op(32'd7, -32'sd2, 1, "R3");
        do_op(-32'sd100, -32'sd7, 1, "R3");
        do_op(-32'sd128, 32'd3, 1, "R5");
        do_op(-32'sd129, 32'd3, 1, "R5");
        do_op(32'd127, 32'd5, 1, "R5");
        do_op(32'd128, 32'd5, 1, "R5");
        do_op(32'hFF80_0000, 32'd1000, 1, "R5");
        do_op(32'h8000_0000, 32'hFFFF_FFFF, 1, "R3");
        do_op(32'h8000_0000, 32'd1, 1, "R3");

        // R8: divide by zero in both modes and two widths
        do_op(32'd77, 32'd0, 0, "R8");
        do_op(32'hF000_0001, 32'd0, 1, "R8");
        do_op(-32'sd3, 32'd0, 1, "R8");

        // R7 and R9
        do_op_noisy(32'h0001_0000, 32'd9, 0);
        do_op_noisy(-32'sd50000, 32'd13, 1);
        back_to_back(32'd99, 32'd4, 32'h00FF_FFFF, 32'd255, 0);
        back_to_back(-32'sd9, 32'd2, 32'h7FFF_FFFF, -32'sd1, 1);

        // Sweep: each width class in turn, both modes, some back-to-back
        for (int i = 0; i < 64; i++) begin
            logic [31:0] a, b;
            int w;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            w = 8 * ((i % 4) + 1);
            a = (w == 32) ? lfsr : (lfsr & ((32'd1 << w) - 1));
            if (i[2] && w != 32) a = 32'($signed(a << (32 - w)) >>> (32 - w));
            b = {16'd0, lfsr[31:16]} >> (i % 12);
            if (i % 16 == 5) b = 32'd0;
            do_op(a, b, i[2], (i % 16 == 5) ? "R8" : (i[2] ? "R3_R5" : "R2_R4"));
        end

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule